// File: doc/BRIEF.md
# SDRAM Access Protection Rule Table

This block holds a table of twenty access protection rules and judges every SDRAM transaction against them in the same cycle. Each transaction presents a byte address, a 12-bit master protection ID, a port number and a secure/non-secure attribute. The block returns a single accept flag. A rule matches when it is valid, the address falls inside its range of 1 MB blocks, the ID falls inside its ID range, the port's bit is set in its port mask, and its security field allows the transaction's attribute. When several rules match, the rule with the lowest number decides. When none matches, a per-port default mask decides.

Software never addresses a rule directly. It fills three staging registers with a rule's range, ID range and attributes. It then writes a rule number together with a commit command into a select register. To inspect a rule, it writes the rule number with a load command and reads the staging registers back. The register interface is a plain single-cycle write strobe with a combinational read mux.

Top module: `prot_rule_table`

## Requirements
- R1: After reset every rule is invalid, and the select, range, ID, attribute and default registers all read as zero. As a result, transactions on ports 0 to 9 are accepted.
- R2: A write to the select register (offset 0) with bit 5 set copies the three staging registers into the rule numbered by bits 4:0 at that clock edge. The new rule takes effect from the next cycle.
- R3: A write to the select register with bit 6 set and bit 5 clear copies the numbered rule into the staging registers, which read back the new contents from the next cycle. When bits 5 and 6 are both set, only the commit is performed.
- R4: The select register reads back the last written rule number in bits 4:0. Bits 5 and 6 always read zero.
- R5: A commit or load that names a rule number of 20 or above changes neither the rule table nor the staging registers.
- R6: Address match: the range register (offset 1) holds the first covered 1 MB block in bits 11:0 and the last covered block in bits 23:12. Both bounds are compared inclusively against transaction address bits 31:20.
- R7: ID match: the ID register (offset 2) holds the lowest ID in bits 11:0 and the highest ID in bits 23:12. Both bounds are inclusive.
- R8: The attribute register (offset 3) has the following fields. Bit 0 allows non-secure transactions and bit 1 allows secure ones. Bit 2 marks the rule valid. Bits 12:3 are the port mask, with bit 3+p for port p. Bit 13 is the result, where 0 accepts and 1 rejects. A rule whose valid bit is clear never matches.
- R9: When more than one rule matches, the lowest-numbered matching rule supplies the result.
- R10: The default register (offset 4, bits 9:0) decides transactions that match no rule. Bit p set rejects port p, and bit p clear accepts it.
- R11: A transaction on a port number of 10 or above is always rejected.
- R12: The accept output is a combinational function of the transaction inputs and the stored table, valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| txn_addr | input | 32 | Transaction byte address |
| txn_id | input | 12 | Transaction master protection ID |
| txn_port | input | 4 | Transaction port number |
| txn_secure | input | 1 | 1 for a secure transaction |
| txn_accept | output | 1 | 1 when the transaction is allowed |

## Verification
The properties assume that register writes and transaction lookups are never evaluated against an unsettled table. The accept output is only meaningful in a cycle where no commit lands on the same edge. The register offset and transaction inputs are also assumed to be known whenever the block is out of reset. The stimulus changes every input only on the falling clock edge. It never issues a write in the cycle a lookup is sampled, and it keeps the offset driven to a defined value at all times. Out-of-range rule numbers and port numbers are driven on purpose, because those are the ignored and rejected cases.

// File: rtl/prot_rule_pkg.sv
`timescale 1ns/1ps
package prot_rule_pkg;
   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RG_SELECT  = 3'd0,
      RG_RANGE   = 3'd1,
      RG_IDS     = 3'd2,
      RG_ATTR    = 3'd3,
      RG_DEFAULT = 3'd4
   } preg_e;

   // command bits in the select register
   localparam int CMD_COMMIT = 5;
   localparam int CMD_LOAD   = 6;

   // attribute word layout (result sits just above the port mask)
   localparam int SEC_NONSEC = 0;
   localparam int SEC_SEC    = 1;
   localparam int ATTR_VALID = 2;
   localparam int ATTR_PMASK = 3;
endpackage

// File: rtl/prot_rule_regs.sv
`timescale 1ns/1ps
module prot_rule_regs
   import prot_rule_pkg::*;
#(
   parameter int NUM_RULES = 20,
   parameter int BLK_W     = 12,
   parameter int ID_W      = 12,
   parameter int NUM_PORTS = 10,
   parameter int DATA_W    = 32,
   localparam int SEL_W    = $clog2(NUM_RULES),
   localparam int RANGE_W  = 2*BLK_W,
   localparam int IDS_W    = 2*ID_W,
   localparam int ATTR_W   = ATTR_PMASK + NUM_PORTS + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [REG_AW-1:0]    cfg_addr,
   input  logic [DATA_W-1:0]    cfg_wdata,
   output logic [DATA_W-1:0]    cfg_rdata,
   output logic                 commit_go,
   output logic                 load_go,
   output logic [SEL_W-1:0]     cmd_idx,
   input  logic [RANGE_W-1:0]   ld_range,
   input  logic [IDS_W-1:0]     ld_ids,
   input  logic [ATTR_W-1:0]    ld_attr,
   output logic [RANGE_W-1:0]   stg_range,
   output logic [IDS_W-1:0]     stg_ids,
   output logic [ATTR_W-1:0]    stg_attr,
   output logic [NUM_PORTS-1:0] dflt_q
);
   localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NUM_RULES-1);

   logic [SEL_W-1:0] sel_q;
   logic             sel_wr;
   logic             idx_ok;
   logic             unused_wdata;

   assign unused_wdata = ^cfg_wdata;
   assign sel_wr    = cfg_we && (cfg_addr == RG_SELECT);
   assign cmd_idx   = cfg_wdata[SEL_W-1:0];
   assign idx_ok    = (cmd_idx <= LAST_IDX);
   assign commit_go = sel_wr && cfg_wdata[CMD_COMMIT] && idx_ok;
   assign load_go   = sel_wr && cfg_wdata[CMD_LOAD] && !cfg_wdata[CMD_COMMIT] && idx_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q     <= '0;
         stg_range <= '0;
         stg_ids   <= '0;
         stg_attr  <= '0;
         dflt_q    <= '0;
      end else begin
         if (sel_wr) sel_q <= cmd_idx;
         if (load_go) begin
            stg_range <= ld_range;
            stg_ids   <= ld_ids;
            stg_attr  <= ld_attr;
         end else if (cfg_we) begin
            if (cfg_addr == RG_RANGE) stg_range <= cfg_wdata[RANGE_W-1:0];
            if (cfg_addr == RG_IDS)   stg_ids   <= cfg_wdata[IDS_W-1:0];
            if (cfg_addr == RG_ATTR)  stg_attr  <= cfg_wdata[ATTR_W-1:0];
         end
         if (cfg_we && cfg_addr == RG_DEFAULT) dflt_q <= cfg_wdata[NUM_PORTS-1:0];
      end
   end

   always_comb begin
      case (cfg_addr)
         RG_SELECT:  cfg_rdata = DATA_W'(sel_q);
         RG_RANGE:   cfg_rdata = DATA_W'(stg_range);
         RG_IDS:     cfg_rdata = DATA_W'(stg_ids);
         RG_ATTR:    cfg_rdata = DATA_W'(stg_attr);
         RG_DEFAULT: cfg_rdata = DATA_W'(dflt_q);
         default:    cfg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/prot_rule_store.sv
`timescale 1ns/1ps
module prot_rule_store #(
   parameter int NUM_RULES = 20,
   parameter int RANGE_W   = 24,
   parameter int IDS_W     = 24,
   parameter int ATTR_W    = 14,
   localparam int SEL_W    = $clog2(NUM_RULES)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              commit_go,
   input  logic [SEL_W-1:0]                  cmd_idx,
   input  logic [RANGE_W-1:0]                wr_range,
   input  logic [IDS_W-1:0]                  wr_ids,
   input  logic [ATTR_W-1:0]                 wr_attr,
   output logic [RANGE_W-1:0]                rd_range,
   output logic [IDS_W-1:0]                  rd_ids,
   output logic [ATTR_W-1:0]                 rd_attr,
   output logic [NUM_RULES-1:0][RANGE_W-1:0] all_range,
   output logic [NUM_RULES-1:0][IDS_W-1:0]   all_ids,
   output logic [NUM_RULES-1:0][ATTR_W-1:0]  all_attr
);
   localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NUM_RULES-1);

   for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
      logic [RANGE_W-1:0] range_q;
      logic [IDS_W-1:0]   ids_q;
      logic [ATTR_W-1:0]  attr_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            range_q <= '0;
            ids_q   <= '0;
            attr_q  <= '0;
         end else if (commit_go && cmd_idx == SEL_W'(g)) begin
            range_q <= wr_range;
            ids_q   <= wr_ids;
            attr_q  <= wr_attr;
         end
      end

      assign all_range[g] = range_q;
      assign all_ids[g]   = ids_q;
      assign all_attr[g]  = attr_q;
   end

   always_comb begin
      rd_range = '0;
      rd_ids   = '0;
      rd_attr  = '0;
      if (cmd_idx <= LAST_IDX) begin
         rd_range = all_range[cmd_idx];
         rd_ids   = all_ids[cmd_idx];
         rd_attr  = all_attr[cmd_idx];
      end
   end
endmodule

// File: rtl/prot_rule_match.sv
`timescale 1ns/1ps
module prot_rule_match
   import prot_rule_pkg::*;
#(
   parameter int NUM_RULES  = 20,
   parameter int ADDR_W     = 32,
   parameter int BLK_LSB    = 20,
   parameter int ID_W       = 12,
   parameter int NUM_PORTS  = 10,
   localparam int PORT_IDX_W = $clog2(NUM_PORTS),
   localparam int BLK_W      = ADDR_W - BLK_LSB,
   localparam int RANGE_W    = 2*BLK_W,
   localparam int IDS_W      = 2*ID_W,
   localparam int ATTR_W     = ATTR_PMASK + NUM_PORTS + 1
) (
   input  logic [NUM_RULES-1:0][RANGE_W-1:0] all_range,
   input  logic [NUM_RULES-1:0][IDS_W-1:0]   all_ids,
   input  logic [NUM_RULES-1:0][ATTR_W-1:0]  all_attr,
   input  logic [NUM_PORTS-1:0]              dflt,
   input  logic [ADDR_W-1:0]                 txn_addr,
   input  logic [ID_W-1:0]                   txn_id,
   input  logic [PORT_IDX_W-1:0]             txn_port,
   input  logic                              txn_secure,
   output logic                              txn_accept
);
   localparam int RES_BIT = ATTR_PMASK + NUM_PORTS;
   localparam logic [PORT_IDX_W-1:0] LAST_PORT = PORT_IDX_W'(NUM_PORTS-1);

   logic [BLK_W-1:0]     blk;
   logic                 port_ok;
   logic [NUM_PORTS-1:0] port_oh;
   logic [NUM_RULES-1:0] hit;
   logic                 any_hit;
   logic                 win_res;
   logic                 unused_low;

   assign unused_low = ^txn_addr[BLK_LSB-1:0];
   assign blk     = txn_addr[ADDR_W-1:BLK_LSB];
   assign port_ok = (txn_port <= LAST_PORT);
   assign port_oh = port_ok ? (NUM_PORTS'(1) << txn_port) : '0;

   for (genvar g = 0; g < NUM_RULES; g++) begin : g_cmp
      logic [BLK_W-1:0]     b_lo, b_hi;
      logic [ID_W-1:0]      i_lo, i_hi;
      logic [NUM_PORTS-1:0] pmask;
      logic                 sec_ok;
      assign b_lo   = all_range[g][BLK_W-1:0];
      assign b_hi   = all_range[g][RANGE_W-1:BLK_W];
      assign i_lo   = all_ids[g][ID_W-1:0];
      assign i_hi   = all_ids[g][IDS_W-1:ID_W];
      assign pmask  = all_attr[g][ATTR_PMASK +: NUM_PORTS];
      assign sec_ok = txn_secure ? all_attr[g][SEC_SEC] : all_attr[g][SEC_NONSEC];
      assign hit[g] = all_attr[g][ATTR_VALID] && (blk >= b_lo) && (blk <= b_hi)
                   && (txn_id >= i_lo) && (txn_id <= i_hi)
                   && (|(pmask & port_oh)) && sec_ok;
   end

   // lowest-numbered hit wins: scan downward so the last assignment is the lowest
   always_comb begin
      any_hit = 1'b0;
      win_res = 1'b0;
      for (int i = NUM_RULES-1; i >= 0; i--) begin
         if (hit[i]) begin
            any_hit = 1'b1;
            win_res = all_attr[i][RES_BIT];
         end
      end
   end

   always_comb begin
      if (!port_ok)     txn_accept = 1'b0;
      else if (any_hit) txn_accept = !win_res;
      else              txn_accept = !(|(dflt & port_oh));
   end
endmodule

// File: rtl/prot_rule_table.sv
`timescale 1ns/1ps
module prot_rule_table
   import prot_rule_pkg::*;
#(
   parameter int NUM_RULES  = 20,
   parameter int ADDR_W     = 32,
   parameter int BLK_LSB    = 20,
   parameter int ID_W       = 12,
   parameter int NUM_PORTS  = 10,
   parameter int DATA_W     = 32,
   localparam int PORT_IDX_W = $clog2(NUM_PORTS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [REG_AW-1:0]     cfg_addr,
   input  logic [DATA_W-1:0]     cfg_wdata,
   output logic [DATA_W-1:0]     cfg_rdata,
   input  logic [ADDR_W-1:0]     txn_addr,
   input  logic [ID_W-1:0]       txn_id,
   input  logic [PORT_IDX_W-1:0] txn_port,
   input  logic                  txn_secure,
   output logic                  txn_accept
);
   localparam int BLK_W   = ADDR_W - BLK_LSB;
   localparam int SEL_W   = $clog2(NUM_RULES);
   localparam int RANGE_W = 2*BLK_W;
   localparam int IDS_W   = 2*ID_W;
   localparam int ATTR_W  = ATTR_PMASK + NUM_PORTS + 1;

   if (SEL_W > CMD_COMMIT) begin : g_bad_sel
      $error("rule index field would overlap the command bits");
   end
   if (RANGE_W > DATA_W || IDS_W > DATA_W || ATTR_W > DATA_W) begin : g_bad_width
      $error("staging field does not fit the register width");
   end
   if (NUM_PORTS < 2 || NUM_RULES < 2) begin : g_bad_count
      $error("at least two ports and two rules are required");
   end

   logic                              commit_go, load_go;
   logic [SEL_W-1:0]                  cmd_idx;
   logic [RANGE_W-1:0]                stg_range, rd_range;
   logic [IDS_W-1:0]                  stg_ids, rd_ids;
   logic [ATTR_W-1:0]                 stg_attr, rd_attr;
   logic [NUM_PORTS-1:0]              dflt_q;
   logic [NUM_RULES-1:0][RANGE_W-1:0] all_range;
   logic [NUM_RULES-1:0][IDS_W-1:0]   all_ids;
   logic [NUM_RULES-1:0][ATTR_W-1:0]  all_attr;

   prot_rule_regs #(
      .NUM_RULES(NUM_RULES), .BLK_W(BLK_W), .ID_W(ID_W),
      .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .commit_go(commit_go), .load_go(load_go), .cmd_idx(cmd_idx),
      .ld_range(rd_range), .ld_ids(rd_ids), .ld_attr(rd_attr),
      .stg_range(stg_range), .stg_ids(stg_ids), .stg_attr(stg_attr),
      .dflt_q(dflt_q)
   );

   prot_rule_store #(
      .NUM_RULES(NUM_RULES), .RANGE_W(RANGE_W), .IDS_W(IDS_W), .ATTR_W(ATTR_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .commit_go(commit_go), .cmd_idx(cmd_idx),
      .wr_range(stg_range), .wr_ids(stg_ids), .wr_attr(stg_attr),
      .rd_range(rd_range), .rd_ids(rd_ids), .rd_attr(rd_attr),
      .all_range(all_range), .all_ids(all_ids), .all_attr(all_attr)
   );

   prot_rule_match #(
      .NUM_RULES(NUM_RULES), .ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB),
      .ID_W(ID_W), .NUM_PORTS(NUM_PORTS)
   ) u_match (
      .all_range(all_range), .all_ids(all_ids), .all_attr(all_attr),
      .dflt(dflt_q), .txn_addr(txn_addr), .txn_id(txn_id),
      .txn_port(txn_port), .txn_secure(txn_secure), .txn_accept(txn_accept)
   );
endmodule

// File: rtl/prot_rule_table_chk.sv
`timescale 1ns/1ps
module prot_rule_table_chk
   import prot_rule_pkg::*;
#(
   parameter int NUM_RULES  = 20,
   parameter int NUM_PORTS  = 10,
   parameter int DATA_W     = 32,
   parameter int RANGE_W    = 24,
   parameter int IDS_W      = 24,
   parameter int ATTR_W     = 14,
   parameter int PORT_IDX_W = 4,
   parameter int SEL_W      = 5
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              cfg_we,
   input logic [REG_AW-1:0]                 cfg_addr,
   input logic [DATA_W-1:0]                 cfg_wdata,
   input logic [DATA_W-1:0]                 cfg_rdata,
   input logic [PORT_IDX_W-1:0]             txn_port,
   input logic                              txn_accept,
   input logic [NUM_PORTS-1:0]              dflt_q,
   input logic [RANGE_W-1:0]                stg_range,
   input logic [IDS_W-1:0]                  stg_ids,
   input logic [ATTR_W-1:0]                 stg_attr,
   input logic [NUM_RULES-1:0][RANGE_W-1:0] all_range,
   input logic [NUM_RULES-1:0][IDS_W-1:0]   all_ids,
   input logic [NUM_RULES-1:0][ATTR_W-1:0]  all_attr
);
   localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NUM_RULES-1);
   localparam logic [PORT_IDX_W-1:0] LAST_PORT = PORT_IDX_W'(NUM_PORTS-1);

   logic             sel_write;
   logic [SEL_W-1:0] w_idx;
   logic             any_valid;
   logic             unused_chk;

   assign unused_chk = ^{cfg_wdata, cfg_rdata};
   assign sel_write  = cfg_we && (cfg_addr == 3'd0);
   assign w_idx      = cfg_wdata[SEL_W-1:0];

   always_comb begin
      any_valid = 1'b0;
      for (int i = 0; i < NUM_RULES; i++) any_valid = any_valid | all_attr[i][ATTR_VALID];
   end

   // R2
   commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_write && cfg_wdata[CMD_COMMIT] && w_idx <= LAST_IDX) |=>
      (all_range[$past(w_idx)] == $past(stg_range) && all_ids[$past(w_idx)] == $past(stg_ids)
       && all_attr[$past(w_idx)] == $past(stg_attr)));

   // R3
   load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_write && cfg_wdata[CMD_LOAD] && !cfg_wdata[CMD_COMMIT] && w_idx <= LAST_IDX) |=>
      (stg_range == $past(all_range[w_idx]) && stg_ids == $past(all_ids[w_idx])
       && stg_attr == $past(all_attr[w_idx])));

   // R4
   sel_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sel_write) && cfg_addr == 3'd0) |->
      (cfg_rdata[SEL_W-1:0] == $past(w_idx) && cfg_rdata[CMD_LOAD:CMD_COMMIT] == 2'b00));

   // R5
   oor_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_write && w_idx > LAST_IDX) |=>
      ($stable(all_range) && $stable(all_ids) && $stable(all_attr)));

   // R11
   bad_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_port > LAST_PORT) |-> !txn_accept);

   // R10
   default_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_valid && txn_port <= LAST_PORT) |-> (txn_accept == !dflt_q[txn_port]));
endmodule

bind prot_rule_table prot_rule_table_chk #(
   .NUM_RULES(NUM_RULES), .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W),
   .RANGE_W(RANGE_W), .IDS_W(IDS_W), .ATTR_W(ATTR_W),
   .PORT_IDX_W(PORT_IDX_W), .SEL_W(SEL_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .txn_port(txn_port),
   .txn_accept(txn_accept), .dflt_q(dflt_q), .stg_range(stg_range),
   .stg_ids(stg_ids), .stg_attr(stg_attr), .all_range(all_range),
   .all_ids(all_ids), .all_attr(all_attr)
);

// File: tb/test_prot_rule_table.sv
`timescale 1ns/1ps
module test_prot_rule_table;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = 3'd0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [31:0] txn_addr = '0;
   logic [11:0] txn_id = '0;
   logic [3:0]  txn_port = '0;
   logic        txn_secure = 1'b0;
   logic        txn_accept;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done = 1'b0;

   typedef struct {
      logic  exp;
      string tag;
   } sb_item_t;
   sb_item_t sb_q[$];

   always #2.5 clk = ~clk;

   prot_rule_table i_prot_rule_table (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .txn_addr(txn_addr),
      .txn_id(txn_id), .txn_port(txn_port), .txn_secure(txn_secure),
      .txn_accept(txn_accept)
   );

   task automatic note(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      end
   endtask

   // monitor: pops expected decisions, samples 1 ns after the rising edge
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         sb_item_t it;
         it = sb_q.pop_front();
         note(it.tag, {31'd0, txn_accept}, {31'd0, it.exp});
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0; cfg_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      cfg_addr = a;
      #1;
      note(tag, cfg_rdata, exp);
   endtask

   task automatic txn(input logic [31:0] a, input logic [11:0] id, input logic [3:0] p,
                      input logic s, input logic exp, input string tag);
      @(negedge clk);
      txn_addr = a; txn_id = id; txn_port = p; txn_secure = s;
      sb_q.push_back('{exp, tag});
      @(negedge clk);
   endtask

   task automatic prog(input int n, input logic [11:0] b0, input logic [11:0] b1,
                       input logic [11:0] i0, input logic [11:0] i1, input logic [1:0] sec,
                       input logic v, input logic [9:0] pm, input logic res);
      wr(3'd1, {8'd0, b1, b0});
      wr(3'd2, {8'd0, i1, i0});
      wr(3'd3, {18'd0, res, pm, v, sec});
      wr(3'd0, 32'(n) | 32'h20);
   endtask

   task automatic clear_all();
      wr(3'd1, 0); wr(3'd2, 0); wr(3'd3, 0);
      for (int r = 0; r < 20; r++) wr(3'd0, 32'(r) | 32'h20);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      report();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(3'd0, 0, "R1 select"); rd(3'd1, 0, "R1 range"); rd(3'd2, 0, "R1 ids");
      rd(3'd3, 0, "R1 attr");   rd(3'd4, 0, "R1 default");
      txn(32'h1234_5678, 12'h005, 4'd0, 1'b0, 1'b1, "R1 port0 after reset");
      txn(32'hFFFF_FFFF, 12'hFFF, 4'd9, 1'b1, 1'b1, "R12 port9 after reset");

      // R10 default mask
      wr(3'd4, 32'h3FF);
      txn(32'h0, 12'h0, 4'd3, 1'b0, 1'b0, "R10 all ports rejected");
      wr(3'd4, 32'h004);
      rd(3'd4, 32'h004, "R10 default readback");
      txn(32'h0, 12'h0, 4'd2, 1'b0, 1'b0, "R10 port2 rejected");
      txn(32'h0, 12'h0, 4'd1, 1'b0, 1'b1, "R10 port1 accepted");

      // R11 bad port
      wr(3'd4, 32'h0);
      txn(32'h0, 12'h0, 4'd12, 1'b0, 1'b0, "R11 port12");
      txn(32'h0, 12'h0, 4'd15, 1'b1, 1'b0, "R11 port15");

      // R6 address range inclusive
      wr(3'd4, 32'h3FF);
      prog(0, 12'h100, 12'h1FF, 12'h000, 12'hFFF, 2'b11, 1'b1, 10'h3FF, 1'b0);
      txn(32'h1000_0000, 12'h5, 4'd0, 1'b0, 1'b1, "R6 first block");
      txn(32'h1FFF_FFFF, 12'h5, 4'd0, 1'b0, 1'b1, "R6 last block inclusive");
      txn(32'h0FFF_FFFF, 12'h5, 4'd0, 1'b0, 1'b0, "R6 below start");
      txn(32'h2000_0000, 12'h5, 4'd0, 1'b0, 1'b0, "R6 above end");

      // R7 ID range
      prog(0, 12'h000, 12'hFFF, 12'h010, 12'h020, 2'b11, 1'b1, 10'h3FF, 1'b0);
      txn(32'h0, 12'h00F, 4'd0, 1'b0, 1'b0, "R7 id below");
      txn(32'h0, 12'h010, 4'd0, 1'b0, 1'b1, "R7 id low bound");
      txn(32'h0, 12'h020, 4'd0, 1'b0, 1'b1, "R7 id high bound");
      txn(32'h0, 12'h021, 4'd0, 1'b0, 1'b0, "R7 id above");

      // R8 port mask, security, valid, result
      prog(0, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 2'b11, 1'b1, 10'h002, 1'b0);
      txn(32'h0, 12'h0, 4'd1, 1'b0, 1'b1, "R8 port in mask");
      txn(32'h0, 12'h0, 4'd0, 1'b0, 1'b0, "R8 port0 outside mask");
      txn(32'h0, 12'h0, 4'd9, 1'b0, 1'b0, "R8 port9 outside mask");
      prog(0, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 2'b01, 1'b1, 10'h3FF, 1'b0);
      txn(32'h0, 12'h0, 4'd0, 1'b0, 1'b1, "R8 nonsecure allowed");
      txn(32'h0, 12'h0, 4'd0, 1'b1, 1'b0, "R8 secure refused");
      prog(0, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 2'b10, 1'b1, 10'h3FF, 1'b0);
      txn(32'h0, 12'h0, 4'd0, 1'b0, 1'b0, "R8 nonsecure refused");
      txn(32'h0, 12'h0, 4'd0, 1'b1, 1'b1, "R8 secure allowed");
      prog(0, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 2'b11, 1'b0, 10'h3FF, 1'b0);
      txn(32'h0, 12'h0, 4'd0, 1'b0, 1'b0, "R8 invalid rule ignored");
      wr(3'd4, 32'h0);
      prog(0, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 2'b11, 1'b1, 10'h3FF, 1'b1);
      txn(32'h0, 12'h0, 4'd0, 1'b0, 1'b0, "R8 result reject");

      // R9 priority: rule0 rejects, rule7 accepts
      prog(7, 12'h000, 12'hFFE, 12'h001, 12'hFFF, 2'b11, 1'b1, 10'h3FF, 1'b0);
      txn(32'h1000_0000, 12'h5, 4'd0, 1'b0, 1'b0, "R9 rule0 over rule7");
      wr(3'd4, 32'h3FF);
      prog(0, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 2'b11, 1'b0, 10'h3FF, 1'b0);
      txn(32'h1000_0000, 12'h5, 4'd0, 1'b0, 1'b1, "R9 rule7 alone");
      prog(3, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 2'b11, 1'b1, 10'h3FF, 1'b1);
      txn(32'h1000_0000, 12'h5, 4'd0, 1'b0, 1'b0, "R9 rule3 over rule7");

      // R3 / R4 load readback
      wr(3'd0, 32'h47);
      rd(3'd0, 32'h07, "R4 select shows index, command zero");
      rd(3'd1, 32'h00FF_E000, "R3 range loaded");
      rd(3'd2, 32'h00FF_F001, "R3 ids loaded");
      rd(3'd3, 32'h0000_1FFF, "R3 attr loaded");
      // commit wins when both bits set: rule3 gets rule7 contents
      wr(3'd0, 32'h63);
      rd(3'd0, 32'h03, "R4 select after dual command");
      rd(3'd3, 32'h0000_1FFF, "R3 staging untouched by dual command");
      txn(32'h1000_0000, 12'h5, 4'd0, 1'b0, 1'b1, "R3 dual command committed");

      // R5 out-of-range rule number
      wr(3'd1, 32'h00AB_C123);
      wr(3'd0, 32'h59);
      rd(3'd1, 32'h00AB_C123, "R5 load ignored");
      rd(3'd0, 32'h19, "R4 select holds 25");
      wr(3'd1, 32'h00FF_F000); wr(3'd2, 32'h00FF_F000); wr(3'd3, 32'h0000_3FFF);
      wr(3'd0, 32'h39);
      txn(32'h1000_0000, 12'h5, 4'd0, 1'b0, 1'b1, "R5 commit ignored");

      // R2 highest rule, commit and revoke
      clear_all();
      txn(32'h1000_0000, 12'h5, 4'd4, 1'b0, 1'b0, "R2 cleared table");
      prog(19, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 2'b11, 1'b1, 10'h3FF, 1'b0);
      txn(32'h1000_0000, 12'h5, 4'd4, 1'b0, 1'b1, "R2 rule19 committed");
      prog(19, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 2'b11, 1'b0, 10'h3FF, 1'b0);
      txn(32'h1000_0000, 12'h5, 4'd4, 1'b0, 1'b0, "R2 rule19 revoked");

      wait (sb_q.size() == 0);
      @(negedge clk);
      report();
      $finish;
   end
endmodule